// File: doc/BRIEF.md
# Pipelined Crossbar Switch with Rotating Output Arbitration

This block moves fixed-length packets from any of N input ports to any of N output ports. Each input offers a packet, a binary destination index and a valid flag. A source-side control slice at every input turns the destination index into a one-hot request toward the outputs. A target-side control slice at every output runs a rotating arbiter over the inputs that ask for it, picks one, and steers that input's packet through an AND-OR selector into a fixed-depth register pipeline. The chosen input sees its ready flag high in the same cycle and may then present its next packet.

An input that is not chosen sees ready low and keeps its packet on the port until it wins. There is exactly one path between any input and any output, so packets between one pair always leave in the order they were accepted. When no two inputs target the same output, all N inputs are accepted in the same cycle, giving a peak of N packets per cycle. The outputs have no backpressure: each has a valid flag and a data bus that are good for one cycle. Default sizing is 8 ports, 95-bit packets and 7 pipeline stages. The port count, packet width and depth are parameters and scale up to a 96-port build.

Top module: `xbar_switch`

## Requirements
- R1: An asynchronous active-low reset clears every output valid flag at once, discards packets already in the pipeline, and returns every arbiter's top priority to input 0.
- R2: A packet accepted in cycle c (in_valid and in_ready both high) appears on output in_dest in cycle c+DEPTH (default 7), with out_data equal to the accepted in_data. No earlier or later cycle shows it.
- R3: in_ready is high only while in_valid is high. A valid input whose destination no other valid input targets is granted in the same cycle.
- R4: In each cycle an output grants at most one input. It grants exactly one when at least one valid input targets it.
- R5: Each output keeps a priority position, which is input 0 after reset. The grant goes to the first requesting input found from that position upward in index order, wrapping from N-1 to 0. After a grant to input i, the position becomes (i+1) mod N.
- R6: An input that loses sees in_ready low. Held unchanged, its packet is delivered unaltered once it wins.
- R7: When the valid inputs target pairwise distinct outputs, all of them are accepted in one cycle, and every targeted output is valid DEPTH cycles later.
- R8: Packets from one input to one output leave in the order they were accepted.
- R9: An input that keeps its request steady loses for at most N-1 consecutive cycles.
- R10: An output is valid only in a cycle that lies DEPTH cycles after a grant to that output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| in_valid | input | N_PORTS | Per-input packet valid |
| in_dest | input | N_PORTS x clog2(N_PORTS) | Per-input binary destination output index |
| in_data | input | N_PORTS x PKT_W | Per-input packet |
| in_ready | output | N_PORTS | Per-input grant; packet accepted when high with in_valid |
| out_valid | output | N_PORTS | Per-output packet valid |
| out_data | output | N_PORTS x PKT_W | Per-output packet |

## Verification
The bound checker examines every cycle. It confirms that each output grants exactly one of its requesters, that ready never rises without valid, and that an uncontested input is always granted. It also checks that no held request loses N times running, and that out_valid follows the grant pattern exactly DEPTH cycles later. What those properties cannot show needs the bench's scenarios: which input the rotating pointer picks, whether the data that emerges is the data that was accepted, whether per-pair order survives heavy contention, and whether a reset in mid-flight drops the packets in transit.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  // Circular successor of an index inside a ring of n positions.
  function automatic int unsigned ring_next(input int unsigned idx, input int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  // Width of an index into n items, never below one bit.
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/xbar_rr_arb.sv
module xbar_rr_arb
  import xbar_pkg::*;
#(
  parameter int N_REQ = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req,
  output logic [N_REQ-1:0] gnt
);

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] ptr_d;
  logic             ptr_en;
  logic [N_REQ-1:0] upper_mask;
  logic [N_REQ-1:0] req_upper;

  function automatic logic [N_REQ-1:0] lowest_set(input logic [N_REQ-1:0] v);
    return v & (~v + {{(N_REQ-1){1'b0}}, 1'b1});
  endfunction

  // Thermometer mask: positions at or above the priority pointer.
  always_comb begin
    for (int k = 0; k < N_REQ; k++) begin
      upper_mask[k] = (k >= int'(ptr_q));
    end
    req_upper = req & upper_mask;
  end

  // Two-pass pick: first requester at/above pointer, else first overall.
  always_comb begin
    if (|req_upper) gnt = lowest_set(req_upper);
    else            gnt = lowest_set(req);
  end

  // Next priority position: neighbour after the winner.
  always_comb begin
    ptr_en = |req;
    ptr_d  = ptr_q;
    for (int k = 0; k < N_REQ; k++) begin
      if (gnt[k]) ptr_d = IDX_W'(ring_next(k, N_REQ));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

endmodule

// File: rtl/xbar_pipe.sv
module xbar_pipe #(
  parameter int DEPTH = 7,
  parameter int WIDTH = 95
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_v,
  input  logic [WIDTH-1:0] in_d,
  output logic             out_v,
  output logic [WIDTH-1:0] out_d
);

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic             v_q;
    logic [WIDTH-1:0] d_q;
    logic             v_nxt;
    logic [WIDTH-1:0] d_nxt;

    if (s == 0) begin : g_head
      assign v_nxt = in_v;
      assign d_nxt = in_d;
    end else begin : g_body
      assign v_nxt = g_stage[s-1].v_q;
      assign d_nxt = g_stage[s-1].d_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= v_nxt;
    end

    // Data flops carry no reset; loaded only under a valid token.
    always_ff @(posedge clk) begin
      if (v_nxt) d_q <= d_nxt;
    end
  end

  assign out_v = g_stage[DEPTH-1].v_q;
  assign out_d = g_stage[DEPTH-1].d_q;

endmodule

// File: rtl/xbar_src_ctl.sv
module xbar_src_ctl #(
  parameter int N_OUT = 8,
  parameter int IDX_W = 3
) (
  input  logic             valid,
  input  logic [IDX_W-1:0] dest,
  input  logic [N_OUT-1:0] gnt_from_out,
  output logic [N_OUT-1:0] req_to_out,
  output logic             ready
);

  always_comb begin
    for (int j = 0; j < N_OUT; j++) begin
      req_to_out[j] = valid && (dest == IDX_W'(j));
    end
  end

  assign ready = |(gnt_from_out & req_to_out);

endmodule

// File: rtl/xbar_tgt_ctl.sv
module xbar_tgt_ctl #(
  parameter int N_IN  = 8,
  parameter int WIDTH = 95,
  parameter int DEPTH = 7,
  parameter int IDX_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_IN-1:0]            req,
  input  logic [N_IN-1:0][WIDTH-1:0] src_data,
  output logic [N_IN-1:0]            gnt,
  output logic                       out_v,
  output logic [WIDTH-1:0]           out_d
);

  logic             sel_v;
  logic [WIDTH-1:0] sel_d;

  xbar_rr_arb #(
    .N_REQ (N_IN),
    .IDX_W (IDX_W)
  ) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .gnt   (gnt)
  );

  // One-hot AND-OR selector: depth is log2(N_IN) OR levels.
  always_comb begin
    sel_d = '0;
    for (int i = 0; i < N_IN; i++) begin
      sel_d = sel_d | (src_data[i] & {WIDTH{gnt[i]}});
    end
    sel_v = |gnt;
  end

  xbar_pipe #(
    .DEPTH (DEPTH),
    .WIDTH (WIDTH)
  ) u_pipe (
    .clk   (clk),
    .rst_n (rst_n),
    .in_v  (sel_v),
    .in_d  (sel_d),
    .out_v (out_v),
    .out_d (out_d)
  );

endmodule

// File: rtl/xbar_switch.sv
module xbar_switch
  import xbar_pkg::*;
#(
  parameter int N_PORTS = 8,
  parameter int PKT_W   = 95,
  parameter int DEPTH   = 7,
  localparam int IDX_W  = idx_width(N_PORTS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_PORTS-1:0]            in_valid,
  input  logic [N_PORTS-1:0][IDX_W-1:0] in_dest,
  input  logic [N_PORTS-1:0][PKT_W-1:0] in_data,
  output logic [N_PORTS-1:0]            in_ready,
  output logic [N_PORTS-1:0]            out_valid,
  output logic [N_PORTS-1:0][PKT_W-1:0] out_data
);

  // Row-major by input: [input][output]
  logic [N_PORTS-1:0][N_PORTS-1:0] req_by_in;
  logic [N_PORTS-1:0][N_PORTS-1:0] gnt_by_in;
  // Row-major by output: [output][input]
  logic [N_PORTS-1:0][N_PORTS-1:0] req_by_out;
  logic [N_PORTS-1:0][N_PORTS-1:0] gnt_by_out;

  always_comb begin
    for (int j = 0; j < N_PORTS; j++) begin
      for (int i = 0; i < N_PORTS; i++) begin
        req_by_out[j][i] = req_by_in[i][j];
        gnt_by_in[i][j]  = gnt_by_out[j][i];
      end
    end
  end

  for (genvar i = 0; i < N_PORTS; i++) begin : g_src
    xbar_src_ctl #(
      .N_OUT (N_PORTS),
      .IDX_W (IDX_W)
    ) u_src (
      .valid        (in_valid[i]),
      .dest         (in_dest[i]),
      .gnt_from_out (gnt_by_in[i]),
      .req_to_out   (req_by_in[i]),
      .ready        (in_ready[i])
    );
  end

  for (genvar j = 0; j < N_PORTS; j++) begin : g_tgt
    xbar_tgt_ctl #(
      .N_IN  (N_PORTS),
      .WIDTH (PKT_W),
      .DEPTH (DEPTH),
      .IDX_W (IDX_W)
    ) u_tgt (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req_by_out[j]),
      .src_data (in_data),
      .gnt      (gnt_by_out[j]),
      .out_v    (out_valid[j]),
      .out_d    (out_data[j])
    );
  end

endmodule

// File: rtl/xbar_switch_chk.sv
module xbar_switch_chk
  import xbar_pkg::*;
#(
  parameter int N_PORTS = 8,
  parameter int DEPTH   = 7,
  localparam int IDX_W  = idx_width(N_PORTS),
  localparam int CW     = idx_width(N_PORTS) + 2
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [N_PORTS-1:0]            in_valid,
  input logic [N_PORTS-1:0][IDX_W-1:0] in_dest,
  input logic [N_PORTS-1:0]            in_ready,
  input logic [N_PORTS-1:0]            out_valid
);

  logic [N_PORTS-1:0][N_PORTS-1:0] asks;      // [output][input]
  logic [N_PORTS-1:0]              took;      // output granted someone
  logic [N_PORTS-1:0]              echo [DEPTH];
  logic [CW-1:0]                   lose_run [N_PORTS];

  always_comb begin
    for (int j = 0; j < N_PORTS; j++) begin
      for (int i = 0; i < N_PORTS; i++) begin
        asks[j][i] = in_valid[i] && (in_dest[i] == IDX_W'(j));
      end
      took[j] = |(asks[j] & in_ready);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < DEPTH; s++) echo[s] <= '0;
    end else begin
      echo[0] <= took;
      for (int s = 1; s < DEPTH; s++) echo[s] <= echo[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_PORTS; i++) lose_run[i] <= '0;
    end else begin
      for (int i = 0; i < N_PORTS; i++) begin
        if (in_valid[i] && !in_ready[i]) begin
          if (lose_run[i] != '1) lose_run[i] <= lose_run[i] + 1'b1;
        end else begin
          lose_run[i] <= '0;
        end
      end
    end
  end

  // R1: outputs idle whenever reset is seen asserted at an edge
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_idle_in_reset: assert (out_valid == '0);
    end
  end

  // R10 / R2: valid shows up exactly DEPTH cycles after a grant
  a_r10_valid_follows_grant: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == echo[DEPTH-1]);

  for (genvar j = 0; j < N_PORTS; j++) begin : g_out
    // R4: one winner per contested output
    a_r4_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
      (asks[j] != '0) |-> ($countones(asks[j] & in_ready) == 1));
  end

  for (genvar i = 0; i < N_PORTS; i++) begin : g_in
    // R3: no ready without valid
    a_r3_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready[i] |-> in_valid[i]);
    // R3 / R7: uncontested path is granted at once
    a_r3_free_path: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[i] && ($countones(asks[in_dest[i]]) == 1)) |-> in_ready[i]);
    // R9: bounded run of lost cycles
    a_r9_bounded_wait: assert property (@(posedge clk) disable iff (!rst_n)
      lose_run[i] < CW'(N_PORTS));
  end

endmodule

bind xbar_switch xbar_switch_chk #(
  .N_PORTS (N_PORTS),
  .DEPTH   (DEPTH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_dest   (in_dest),
  .in_ready  (in_ready),
  .out_valid (out_valid)
);

// File: tb/sim_xbar_switch.sv
`timescale 1ns/1ps
module sim_xbar_switch;

  localparam int N   = 8;
  localparam int PW  = 95;
  localparam int LAT = 7;
  localparam int IW  = 3;
  localparam int RING = 16;
  localparam int QD  = 32;

  // {first-cycle ready expected, valid mask, 3-bit dest per input}
  localparam logic [39:0] VEC [6] = '{
    {8'hFF, 8'hFF, 24'hFAC688},   // identity
    {8'hFF, 8'hFF, 24'h053977},   // reversal
    {8'h01, 8'h0F, 24'h000492},   // four inputs onto output 2
    {8'h20, 8'h22, 24'h020020},   // inputs 1,5 onto output 4
    {8'h01, 8'hFF, 24'h000000},   // all onto output 0
    {8'hFF, 8'hFF, 24'h447D63}    // rotate by three
  };

  logic                     clk;
  logic                     rst_n;
  logic [N-1:0]             in_valid;
  logic [N-1:0][IW-1:0]     in_dest;
  logic [N-1:0][PW-1:0]     in_data;
  logic [N-1:0]             in_ready;
  logic [N-1:0]             out_valid;
  logic [N-1:0][PW-1:0]     out_data;

  xbar_switch #(.N_PORTS(N), .PKT_W(PW), .DEPTH(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk, n_bad, cyc;
  int q_dst [N][QD];
  int q_seq [N][QD];
  int q_head [N];
  int q_cnt [N];
  int seq_ctr [N][N];
  int nxt_seq [N][N];
  int ptr [N];
  int lose [N];
  bit exp_v [N][RING];
  logic [PW-1:0] exp_d [N][RING];
  bit tbl_on;
  logic [N-1:0] tbl_exp;

  function automatic logic [PW-1:0] mkdata(input int src, input int dst, input int seq);
    return {(PW-32)'(64'h9E3779B97F4A7C15 * 64'(src * 4096 + dst * 256 + seq + 1)),
            8'(src), 8'(dst), 16'(seq)};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [PW-1:0] act,
                       input logic [PW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic push(input int i, input int d);
    q_dst[i][q_cnt[i]] = d;
    q_seq[i][q_cnt[i]] = seq_ctr[i][d];
    seq_ctr[i][d]++;
    q_cnt[i]++;
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      ptr[i] = 0; lose[i] = 0; q_head[i] = 0; q_cnt[i] = 0;
      for (int s = 0; s < RING; s++) exp_v[i][s] = 1'b0;
      for (int d = 0; d < N; d++) nxt_seq[i][d] = seq_ctr[i][d];
    end
  endtask

  function automatic bit pending();
    for (int i = 0; i < N; i++) if (q_head[i] < q_cnt[i]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic step();
    logic [N-1:0] mr;
    logic [N-1:0] have;
    int slot, nslot;
    @(negedge clk);
    slot = cyc % RING;
    // output monitor
    for (int j = 0; j < N; j++) begin
      if (exp_v[j][slot])
        check(out_valid[j] && out_data[j] == exp_d[j][slot],
              $sformatf("R2/R6 output %0d packet", j), out_data[j], exp_d[j][slot]);
      else
        check(!out_valid[j], $sformatf("R10 output %0d spurious valid", j),
              PW'(out_valid[j]), '0);
      if (out_valid[j]) begin
        int src, sq;
        src = int'(out_data[j][31:24]);
        sq  = int'(out_data[j][15:0]);
        if (src < N) begin
          check(sq == nxt_seq[src][j], $sformatf("R8 order %0d->%0d", src, j),
                PW'(sq), PW'(nxt_seq[src][j]));
          nxt_seq[src][j] = sq + 1;
        end
      end
      exp_v[j][slot] = 1'b0;
    end
    // drive
    for (int i = 0; i < N; i++) begin
      have[i] = q_head[i] < q_cnt[i];
      if (have[i]) begin
        in_valid[i] = 1'b1;
        in_dest[i]  = IW'(q_dst[i][q_head[i]]);
        in_data[i]  = mkdata(i, q_dst[i][q_head[i]], q_seq[i][q_head[i]]);
      end else begin
        in_valid[i] = 1'b0;
        in_dest[i]  = '0;
        in_data[i]  = '0;
      end
    end
    #1;
    // reference arbitration
    mr = '0;
    for (int j = 0; j < N; j++) begin
      bit found;
      found = 1'b0;
      for (int k = 0; k < N; k++) begin
        int idx;
        idx = (ptr[j] + k) % N;
        if (!found && have[idx] && q_dst[idx][q_head[idx]] == j) begin
          found = 1'b1;
          mr[idx] = 1'b1;
        end
      end
    end
    check(in_ready == mr, "R4/R5 grant pattern", PW'(in_ready), PW'(mr));
    if (tbl_on) begin
      check(in_ready == tbl_exp, "R3/R7 table first-cycle ready", PW'(in_ready), PW'(tbl_exp));
      tbl_on = 1'b0;
    end
    nslot = (cyc + LAT) % RING;
    for (int i = 0; i < N; i++) begin
      if (mr[i]) begin
        int d;
        d = q_dst[i][q_head[i]];
        exp_v[d][nslot] = 1'b1;
        exp_d[d][nslot] = in_data[i];
        ptr[d] = (i + 1) % N;
        q_head[i]++;
        lose[i] = 0;
      end else if (have[i]) begin
        lose[i]++;
        check(lose[i] < N, $sformatf("R9 input %0d starved", i), PW'(lose[i]), PW'(N - 1));
      end
    end
    @(posedge clk);
    cyc++;
  endtask

  task automatic drain();
    while (pending()) step();
    repeat (LAT + 2) step();
  endtask

  task automatic do_reset(input int hold);
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = '0;
    #1;
    check(out_valid == '0, "R1 outputs cleared by reset", PW'(out_valid), '0);
    model_reset();
    repeat (hold) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0; cyc = 0; tbl_on = 1'b0; tbl_exp = '0;
    rst_n = 1'b0; in_valid = '0; in_dest = '0; in_data = '0;
    for (int i = 0; i < N; i++) for (int d = 0; d < N; d++) seq_ctr[i][d] = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check(out_valid == '0, "R1 reset state", PW'(out_valid), '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) step();

    // Vector table
    for (int v = 0; v < 6; v++) begin
      for (int i = 0; i < N; i++)
        if (VEC[v][24 + i]) push(i, int'(VEC[v][3*i +: 3]));
      tbl_exp = VEC[v][39:32];
      tbl_on  = 1'b1;
      drain();
    end

    // R2: isolated packet, exact latency
    push(4, 1);
    drain();

    // R5/R9: every input sends three packets to output 3
    for (int r = 0; r < 3; r++) for (int i = 0; i < N; i++) push(i, 3);
    drain();

    // R8/R7: three streams share output 5 while input 1 streams alone to 6
    for (int r = 0; r < 5; r++) begin
      push(2, 5); push(6, 5); push(1, 6);
      if (r < 3) push(0, 5);
    end
    drain();

    // R1: reset while packets are in flight
    for (int i = 0; i < N; i++) push(i, i);
    repeat (3) step();
    do_reset(2);
    repeat (LAT + 4) step();

    // priority back to input 0 after reset: all onto output 6
    for (int i = 0; i < N; i++) push(i, 6);
    tbl_exp = 8'h01;
    tbl_on  = 1'b1;
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule